// File: doc/BRIEF.md
# DMA Channel Error Detection Unit

This unit sits beside one DMA channel and inspects every access the channel is about to make. It checks three things. The first is the address of the next descriptor the channel fetches. The second is the source and destination addresses of each payload move, each tagged as memory-space or I/O-space. The third is a set of parity and poison strobes from the descriptor read path, the payload read path and the channel's internal data queue. An illegal access sets a sticky cause bit and stops the channel through a one-cycle abort pulse. The channel then sits in a halted state until software clears every cause bit by writing ones to them. An interrupt request is raised while any enabled cause bit is set.

Causes fall into two groups. Controller-side errors are bits 0 to 5: a bad descriptor pointer, an address that disagrees with its space type, a destination inside the forbidden bridge window, and a corrupt descriptor. Memory-side errors are bits 6 to 10: an address beyond the remap ceiling, an address not backed by memory, an address inside the protected window, data-queue parity and poisoned payload. Every cause aborts the channel. There is no read timeout. A channel that is waiting for data may stay in the running state for any number of cycles.

The channel state machine has four states. IDLE goes to RUN on `start`. RUN goes to ABORT on any error; otherwise RUN goes to IDLE on `xfer_done`. ABORT always goes to HALT after one cycle. HALT goes to IDLE once the cause register reads zero.

Top module: `dma_err_monitor`

## Requirements
- R1: While running, a `desc_vld` cycle whose `desc_ptr` has any of bits [4:0] set (not on a 32-byte boundary) sets cause bit 0.
- R2: While running, a `desc_vld` cycle with `desc_ptr >= mem_top` sets cause bit 1.
- R3: I/O-space addresses must lie below 2**IO_AW, and memory-space addresses must lie at or above it. On an `xfer_vld` cycle, a source address that breaks this rule sets bit 2, and a destination address that breaks it sets bit 3.
- R4: On an `xfer_vld` cycle, a memory-space destination with `bridge_lo <= dst_addr <= bridge_hi` sets bit 4.
- R5: `desc_par_err` while running sets bit 5 and aborts the channel.
- R6: On an `xfer_vld` cycle, a memory-space source or destination sets bit 6 if it lies strictly above `remap_limit`. It sets bit 7 if it is `>= mem_top`. It sets bit 8 if it lies within [`prot_lo`, `prot_hi`] inclusive.
- R7: While running, `dq_par_err` sets bit 9 and `poison_err` sets bit 10.
- R8: An error seen in a RUN cycle sets its cause bits at the next edge. `abort` is high for exactly that next cycle, and `halted` is high from the cycle after it. Errors in the same cycle set all their bits together and produce a single abort pulse.
- R9: Cause bits are sticky. A cycle with `clr_we` high clears the bits set in `clr_mask`. The channel stays halted until all bits are zero, and then returns to idle at the next edge.
- R10: `start` has no effect while the channel is aborting or halted.
- R11: `irq` is high exactly when some cause bit is set whose `irq_en` bit is also set.
- R12: Error strobes and illegal addresses presented while the channel is not running leave the cause register at zero.
- R13: No timeout exists. A running channel with no strobes stays running and never aborts, however long it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start command for the channel |
| xfer_done | input | 1 | Transfer finished normally |
| desc_vld | input | 1 | Descriptor pointer presented for checking |
| desc_ptr | input | AW | Next-descriptor pointer |
| desc_par_err | input | 1 | Parity error on a descriptor read |
| xfer_vld | input | 1 | Source and destination presented for checking |
| src_addr | input | AW | Source address |
| src_io | input | 1 | Source is in I/O space (0: memory space) |
| dst_addr | input | AW | Destination address |
| dst_io | input | 1 | Destination is in I/O space (0: memory space) |
| dq_par_err | input | 1 | Parity error on data-queue read |
| poison_err | input | 1 | Poisoned payload returned by memory |
| mem_top | input | AW | First address not backed by memory |
| remap_limit | input | AW | Highest legal physical memory address |
| prot_lo | input | AW | Protected window, low bound |
| prot_hi | input | AW | Protected window, high bound |
| bridge_lo | input | AW | Forbidden bridge window, low bound |
| bridge_hi | input | AW | Forbidden bridge window, high bound |
| irq_en | input | 11 | Per-cause interrupt enable |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 11 | Cause bits to clear |
| cause | output | 11 | Sticky error-cause register |
| abort | output | 1 | Channel abort pulse |
| halted | output | 1 | Channel halted after an error |
| running | output | 1 | Channel running |
| irq | output | 1 | Interrupt request |

## Verification
Several error detectors can fire in the same RUN cycle. Examples are a misaligned pointer together with descriptor parity and payload poison, or a source whose type is wrong while its destination lies inside the bridge window. The state machine must then merge all of them into one cause update and one abort. The bench provokes these collisions in two ways. It drives combined strobes directly, and it sweeps source and destination addresses across the whole small address space so that the window and limit checks overlap. For each case it computes the expected cause vector arithmetically. It requires the full vector to appear at once and `abort` to drop again after exactly one cycle.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;

    localparam int CW          = 11;
    localparam int ALIGN_BITS  = 5;

    localparam int C_PTR_ALIGN = 0;
    localparam int C_PTR_RANGE = 1;
    localparam int C_SRC_TYPE  = 2;
    localparam int C_DST_TYPE  = 3;
    localparam int C_DST_BRIDGE= 4;
    localparam int C_DESC_PAR  = 5;
    localparam int C_REMAP     = 6;
    localparam int C_UNBACKED  = 7;
    localparam int C_PROT      = 8;
    localparam int C_DQ_PAR    = 9;
    localparam int C_POISON    = 10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_ABORT = 2'd2,
        ST_HALT  = 2'd3
    } ch_state_e;

endpackage

// File: rtl/dma_err_addr_chk.sv
module dma_err_addr_chk #(
    parameter int AW     = 32,
    parameter int IO_AW  = 16,
    parameter bit IS_DST = 1'b0
) (
    input  logic [AW-1:0] addr,
    input  logic          is_io,
    input  logic [AW-1:0] mem_top,
    input  logic [AW-1:0] remap_limit,
    input  logic [AW-1:0] prot_lo,
    input  logic [AW-1:0] prot_hi,
    input  logic [AW-1:0] bridge_lo,
    input  logic [AW-1:0] bridge_hi,
    output logic          type_err,
    output logic          remap_err,
    output logic          unbacked_err,
    output logic          prot_err,
    output logic          bridge_err
);
    logic in_io_space;
    logic mem_side;
    logic in_bridge;

    always_comb begin
        in_io_space  = ~|addr[AW-1:IO_AW];
        mem_side     = ~is_io;
        type_err     = is_io ? ~in_io_space : in_io_space;
        remap_err    = mem_side && (addr > remap_limit);
        unbacked_err = mem_side && (addr >= mem_top);
        prot_err     = mem_side && (addr >= prot_lo) && (addr <= prot_hi);
        in_bridge    = (addr >= bridge_lo) && (addr <= bridge_hi);
        bridge_err   = IS_DST && mem_side && in_bridge;
    end
endmodule

// File: rtl/dma_err_detect.sv
module dma_err_detect
    import dma_err_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IO_AW = 16
) (
    input  logic          run,
    input  logic          desc_vld,
    input  logic [AW-1:0] desc_ptr,
    input  logic          desc_par_err,
    input  logic          xfer_vld,
    input  logic [AW-1:0] src_addr,
    input  logic          src_io,
    input  logic [AW-1:0] dst_addr,
    input  logic          dst_io,
    input  logic          dq_par_err,
    input  logic          poison_err,
    input  logic [AW-1:0] mem_top,
    input  logic [AW-1:0] remap_limit,
    input  logic [AW-1:0] prot_lo,
    input  logic [AW-1:0] prot_hi,
    input  logic [AW-1:0] bridge_lo,
    input  logic [AW-1:0] bridge_hi,
    output logic [CW-1:0] set_vec
);
    localparam int NPORT = 2;

    logic [NPORT-1:0][AW-1:0] chk_addr;
    logic [NPORT-1:0]         chk_io;
    logic [NPORT-1:0]         type_err, remap_err, unbacked_err, prot_err, bridge_err;
    logic [CW-1:0]            raw;

    assign chk_addr = {dst_addr, src_addr};
    assign chk_io   = {dst_io, src_io};

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        dma_err_addr_chk #(
            .AW     (AW),
            .IO_AW  (IO_AW),
            .IS_DST (g == 1)
        ) u_chk (
            .addr         (chk_addr[g]),
            .is_io        (chk_io[g]),
            .mem_top      (mem_top),
            .remap_limit  (remap_limit),
            .prot_lo      (prot_lo),
            .prot_hi      (prot_hi),
            .bridge_lo    (bridge_lo),
            .bridge_hi    (bridge_hi),
            .type_err     (type_err[g]),
            .remap_err    (remap_err[g]),
            .unbacked_err (unbacked_err[g]),
            .prot_err     (prot_err[g]),
            .bridge_err   (bridge_err[g])
        );
    end

    always_comb begin
        raw               = '0;
        raw[C_PTR_ALIGN]  = desc_vld && (|desc_ptr[ALIGN_BITS-1:0]);
        raw[C_PTR_RANGE]  = desc_vld && (desc_ptr >= mem_top);
        raw[C_SRC_TYPE]   = xfer_vld && type_err[0];
        raw[C_DST_TYPE]   = xfer_vld && type_err[1];
        raw[C_DST_BRIDGE] = xfer_vld && (|bridge_err);
        raw[C_DESC_PAR]   = desc_par_err;
        raw[C_REMAP]      = xfer_vld && (|remap_err);
        raw[C_UNBACKED]   = xfer_vld && (|unbacked_err);
        raw[C_PROT]       = xfer_vld && (|prot_err);
        raw[C_DQ_PAR]     = dq_par_err;
        raw[C_POISON]     = poison_err;
        set_vec           = run ? raw : '0;
    end
endmodule

// File: rtl/dma_err_cause.sv
module dma_err_cause
    import dma_err_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] set_vec,
    input  logic          clr_we,
    input  logic [CW-1:0] clr_mask,
    output logic [CW-1:0] cause
);
    logic [CW-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause <= '0;
        else        cause <= (cause & ~clr_eff) | set_vec;
    end
endmodule

// File: rtl/dma_err_fsm.sv
module dma_err_fsm
    import dma_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic xfer_done,
    input  logic any_err,
    input  logic cause_zero,
    output logic running,
    output logic abort,
    output logic halted
);
    ch_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (start)          state_nxt = ST_RUN;
            ST_RUN:   if (any_err)        state_nxt = ST_ABORT;
                      else if (xfer_done) state_nxt = ST_IDLE;
            ST_ABORT:                     state_nxt = ST_HALT;
            ST_HALT:  if (cause_zero)     state_nxt = ST_IDLE;
            default:                      state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        running = (state == ST_RUN);
        abort   = (state == ST_ABORT);
        halted  = (state == ST_HALT);
    end
endmodule

// File: rtl/dma_err_monitor.sv
module dma_err_monitor
    import dma_err_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IO_AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          xfer_done,
    input  logic          desc_vld,
    input  logic [AW-1:0] desc_ptr,
    input  logic          desc_par_err,
    input  logic          xfer_vld,
    input  logic [AW-1:0] src_addr,
    input  logic          src_io,
    input  logic [AW-1:0] dst_addr,
    input  logic          dst_io,
    input  logic          dq_par_err,
    input  logic          poison_err,
    input  logic [AW-1:0] mem_top,
    input  logic [AW-1:0] remap_limit,
    input  logic [AW-1:0] prot_lo,
    input  logic [AW-1:0] prot_hi,
    input  logic [AW-1:0] bridge_lo,
    input  logic [AW-1:0] bridge_hi,
    input  logic [CW-1:0] irq_en,
    input  logic          clr_we,
    input  logic [CW-1:0] clr_mask,
    output logic [CW-1:0] cause,
    output logic          abort,
    output logic          halted,
    output logic          running,
    output logic          irq
);
    logic [CW-1:0] set_vec;

    dma_err_detect #(.AW(AW), .IO_AW(IO_AW)) u_detect (
        .run          (running),
        .desc_vld     (desc_vld),
        .desc_ptr     (desc_ptr),
        .desc_par_err (desc_par_err),
        .xfer_vld     (xfer_vld),
        .src_addr     (src_addr),
        .src_io       (src_io),
        .dst_addr     (dst_addr),
        .dst_io       (dst_io),
        .dq_par_err   (dq_par_err),
        .poison_err   (poison_err),
        .mem_top      (mem_top),
        .remap_limit  (remap_limit),
        .prot_lo      (prot_lo),
        .prot_hi      (prot_hi),
        .bridge_lo    (bridge_lo),
        .bridge_hi    (bridge_hi),
        .set_vec      (set_vec)
    );

    dma_err_cause u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .cause    (cause)
    );

    dma_err_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .xfer_done  (xfer_done),
        .any_err    (|set_vec),
        .cause_zero (cause == '0),
        .running    (running),
        .abort      (abort),
        .halted     (halted)
    );

    assign irq = |(cause & irq_en);
endmodule

// File: rtl/dma_err_monitor_chk.sv
module dma_err_monitor_chk
    import dma_err_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          desc_vld,
    input logic [AW-1:0] desc_ptr,
    input logic          desc_par_err,
    input logic          xfer_vld,
    input logic          dq_par_err,
    input logic          poison_err,
    input logic          clr_we,
    input logic [CW-1:0] cause,
    input logic          abort,
    input logic          halted,
    input logic          running
);
    AST_MISALIGNED_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (running && desc_vld && |desc_ptr[ALIGN_BITS-1:0]) |=> (abort && cause[C_PTR_ALIGN])); // R1

    AST_DESC_PARITY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (running && desc_par_err) |=> (abort && cause[C_DESC_PAR])); // R5

    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!abort && halted)); // R8

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((cause & $past(cause)) == $past(cause))); // R9

    AST_HALT_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        ((halted || abort) && start) |=> !running); // R10

    AST_IDLE_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !halted && !abort) |=> (cause == '0)); // R12

    AST_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !desc_vld && !xfer_vld && !desc_par_err && !dq_par_err && !poison_err)
        |=> !abort); // R13
endmodule

bind dma_err_monitor dma_err_monitor_chk #(.AW(AW)) u_monitor_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .desc_vld     (desc_vld),
    .desc_ptr     (desc_ptr),
    .desc_par_err (desc_par_err),
    .xfer_vld     (xfer_vld),
    .dq_par_err   (dq_par_err),
    .poison_err   (poison_err),
    .clr_we       (clr_we),
    .cause        (cause),
    .abort        (abort),
    .halted       (halted),
    .running      (running)
);

// File: tb/test_dma_err_monitor.sv
module test_dma_err_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 12;
    localparam int IO_AW = 6;
    localparam int CW    = 11;
    localparam int IOSP  = 1 << IO_AW;

    localparam logic [AW-1:0] MEM_TOP = 12'hC00;
    localparam logic [AW-1:0] REMAP   = 12'hD00;
    localparam logic [AW-1:0] PROT_LO = 12'h300;
    localparam logic [AW-1:0] PROT_HI = 12'h37F;
    localparam logic [AW-1:0] BR_LO   = 12'h500;
    localparam logic [AW-1:0] BR_HI   = 12'h5FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, xfer_done = 0, desc_vld = 0, desc_par_err = 0, xfer_vld = 0;
    logic src_io = 0, dst_io = 0, dq_par_err = 0, poison_err = 0, clr_we = 0;
    logic [AW-1:0] desc_ptr = '0, src_addr = '0, dst_addr = '0;
    logic [CW-1:0] irq_en = '1, clr_mask = '0;
    logic [CW-1:0] cause;
    logic abort, halted, running, irq;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_err_monitor #(.AW(AW), .IO_AW(IO_AW)) i_dma_err_monitor (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_done(xfer_done),
        .desc_vld(desc_vld), .desc_ptr(desc_ptr), .desc_par_err(desc_par_err),
        .xfer_vld(xfer_vld), .src_addr(src_addr), .src_io(src_io),
        .dst_addr(dst_addr), .dst_io(dst_io), .dq_par_err(dq_par_err),
        .poison_err(poison_err), .mem_top(MEM_TOP), .remap_limit(REMAP),
        .prot_lo(PROT_LO), .prot_hi(PROT_HI), .bridge_lo(BR_LO), .bridge_hi(BR_HI),
        .irq_en(irq_en), .clr_we(clr_we), .clr_mask(clr_mask),
        .cause(cause), .abort(abort), .halted(halted), .running(running), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] model(
        input logic dv, input logic [AW-1:0] dp, input logic dpar, input logic xv,
        input logic [AW-1:0] sa, input logic si, input logic [AW-1:0] da, input logic di,
        input logic qp, input logic pp);
        logic [CW-1:0] e = '0;
        int s = int'(sa);
        int d = int'(da);
        e[0]  = dv && (dp % 32 != 0);
        e[1]  = dv && (int'(dp) >= int'(MEM_TOP));
        e[2]  = xv && (si ? (s >= IOSP) : (s < IOSP));
        e[3]  = xv && (di ? (d >= IOSP) : (d < IOSP));
        e[4]  = xv && !di && d >= int'(BR_LO) && d <= int'(BR_HI);
        e[5]  = dpar;
        e[6]  = xv && ((!si && s > int'(REMAP)) || (!di && d > int'(REMAP)));
        e[7]  = xv && ((!si && s >= int'(MEM_TOP)) || (!di && d >= int'(MEM_TOP)));
        e[8]  = xv && ((!si && s >= int'(PROT_LO) && s <= int'(PROT_HI)) ||
                       (!di && d >= int'(PROT_LO) && d <= int'(PROT_HI)));
        e[9]  = qp;
        e[10] = pp;
        return e;
    endfunction

    task automatic release_all();
        clr_we = 1; clr_mask = '1; xfer_done = 1;
        @(negedge clk);
        clr_we = 0; clr_mask = '0; xfer_done = 0;
        @(negedge clk);
    endtask

    task automatic start_ch();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic run_case(input logic dv, input logic [AW-1:0] dp, input logic dpar,
                            input logic xv, input logic [AW-1:0] sa, input logic si,
                            input logic [AW-1:0] da, input logic di,
                            input logic qp, input logic pp, input string req);
        logic [CW-1:0] exp, got;
        logic ab1, ab2, hl, iq;
        bit err;
        exp = model(dv, dp, dpar, xv, sa, si, da, di, qp, pp);
        err = (exp != '0);
        start_ch();
        desc_vld = dv; desc_ptr = dp; desc_par_err = dpar; xfer_vld = xv;
        src_addr = sa; src_io = si; dst_addr = da; dst_io = di;
        dq_par_err = qp; poison_err = pp;
        @(negedge clk);
        desc_vld = 0; desc_par_err = 0; xfer_vld = 0; dq_par_err = 0; poison_err = 0;
        got = cause; ab1 = abort;
        @(negedge clk);
        ab2 = abort; hl = halted; iq = irq;
        chk(got == exp, req, int'(got), int'(exp));
        chk(ab1 == err && !ab2 && hl == err && iq == (|(exp & irq_en)),
            {req, " R8 abort/halt/irq"}, int'({ab1, ab2, hl, iq}),
            int'({err, 1'b0, err, |(exp & irq_en)}));
        release_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cause == '0 && !abort && !halted && !running && !irq, "reset state",
            int'({cause, abort, halted, running, irq}), 0);

        // R1 R2: every descriptor pointer in the small address space
        for (int p = 0; p < (1 << AW); p++)
            run_case(1, AW'(p), 0, 0, '0, 0, '0, 0, 0, 0, "R1 R2 desc ptr sweep");

        // R3 R6: source sweep, both space types, legal destination
        for (int a = 0; a < (1 << AW); a += 4)
            for (int t = 0; t < 2; t++)
                run_case(0, '0, 0, 1, AW'(a), t[0], 12'h100, 0, 0, 0, "R3 R6 source sweep");

        // R3 R4 R6: destination sweep with legal source
        for (int a = 0; a < (1 << AW); a += 4)
            for (int t = 0; t < 2; t++)
                run_case(0, '0, 0, 1, 12'h100, 0, AW'(a), t[0], 0, 0, "R3 R4 R6 dest sweep");

        // R5 R7: each parity/poison strobe alone
        run_case(0, '0, 1, 0, '0, 0, '0, 0, 0, 0, "R5 descriptor parity");
        run_case(0, '0, 0, 0, '0, 0, '0, 0, 1, 0, "R7 data queue parity");
        run_case(0, '0, 0, 0, '0, 0, '0, 0, 0, 1, "R7 payload poison");

        // R8: several errors in one cycle
        run_case(1, 12'hC01, 1, 1, 12'h010, 0, 12'h520, 1, 1, 1, "R8 combined errors");
        run_case(0, '0, 0, 1, 12'h340, 0, 12'hE00, 0, 0, 0, "R8 src prot + dst remap");

        // R9 R10: partial clear keeps channel halted; start ignored
        start_ch();
        dq_par_err = 1; poison_err = 1;
        @(negedge clk);
        dq_par_err = 0; poison_err = 0;
        @(negedge clk);
        start = 1;
        repeat (3) @(negedge clk);
        chk(!running && halted, "R10 start ignored while halted",
            int'({running, halted}), 1);
        start = 0;
        clr_we = 1; clr_mask = 11'h200;
        @(negedge clk);
        clr_we = 0; clr_mask = '0;
        @(negedge clk);
        chk(cause == 11'h400 && halted, "R9 partial clear sticky",
            int'({halted, cause}), int'({1'b1, 11'h400}));
        clr_we = 1; clr_mask = 11'h400;
        @(negedge clk);
        clr_we = 0; clr_mask = '0;
        chk(cause == '0 && halted, "R9 cleared, still halted one cycle",
            int'({halted, cause}), int'({1'b1, 11'h000}));
        @(negedge clk);
        chk(!halted && !running, "R9 return to idle", int'({halted, running}), 0);

        // R11: interrupt enable mask
        irq_en = 11'h400;
        run_case(0, '0, 0, 0, '0, 0, '0, 0, 1, 0, "R11 masked cause");
        run_case(0, '0, 0, 0, '0, 0, '0, 0, 0, 1, "R11 enabled cause");
        irq_en = '1;

        // R12: strobes while idle
        @(negedge clk);
        desc_vld = 1; desc_ptr = 12'hFFF; desc_par_err = 1; xfer_vld = 1;
        src_addr = 12'hFFF; dst_addr = 12'h001; dq_par_err = 1; poison_err = 1;
        repeat (2) @(negedge clk);
        chk(cause == '0 && !abort && !halted, "R12 ignored while idle",
            int'({cause, abort, halted}), 0);
        desc_vld = 0; desc_par_err = 0; xfer_vld = 0; dq_par_err = 0; poison_err = 0;

        // R13: long wait while running
        start_ch();
        repeat (3000) @(negedge clk);
        chk(running && !abort && cause == '0, "R13 no timeout",
            int'({running, abort, cause}), int'({1'b1, 1'b0, 11'h000}));
        release_all();
        chk(!running && !halted, "R13 normal completion to idle",
            int'({running, halted}), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule